// File: doc/BRIEF.md
# Button-Selected Serial Mode Controller

This block sits between three push-buttons, a byte-wide serial receiver and a byte-wide serial transmitter. It decides which of three operating modes is active.

- **Quiet mode.** Nothing moves on the serial link.
- **Listening mode.** Every byte the receiver delivers is shown on eight LEDs, one bit per LED.
- **Beacon mode.** A fixed byte is offered to the transmitter again and again. A new copy is offered the moment the previous one is taken, so frames go out back to back.

Each button passes through a synchronizer and a debouncer. Only the press edge of a clean press changes the mode. When several presses land in the same cycle, a fixed priority picks the winner. The serializer and deserializer are outside this block. The block only sees their byte-level strobes: a receive byte with a one-cycle valid strobe, and a transmit byte with a valid/ready handshake.

Top module: `serial_mode_ctrl`

## Requirements
- R1: After reset the mode is quiet, every LED is dark (`led_o` = 0 with `LED_ACTIVE_LOW`=0) and `tx_valid_o` is 0.
- R2: In quiet mode no new transmit offer starts. `tx_valid_o` stays 0 whatever `tx_ready_i` does.
- R3: In listening mode, a cycle with `rx_valid_i`=1 makes `led_o` equal `rx_data_i` (bit i drives LED i) from the following cycle onward.
- R4: In quiet or beacon mode, received bytes are ignored and `led_o` does not change.
- R5: On leaving listening mode, `led_o` keeps the last byte received.
- R6: In beacon mode `tx_valid_o` is 1 and `tx_data_o` is `TX_PATTERN` (0xFF by default). Whenever `tx_valid_o` is 0, `tx_data_o` is 0.
- R7: In beacon mode, a handshake cycle (`tx_valid_o`=1 and `tx_ready_i`=1) is followed directly by the next offer, so `tx_valid_o` stays 1.
- R8: An offer that is not yet accepted is never withdrawn, even when the mode changes. `tx_valid_o` falls only in the cycle after a handshake outside beacon mode.
- R9: Presses landing in the same cycle resolve with quiet first, then listening, then beacon.
- R10: A button level shorter than `DEBOUNCE_CYCLES` consecutive cycles after synchronization causes no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_quiet_i | input | 1 | Raw button selecting quiet mode |
| btn_listen_i | input | 1 | Raw button selecting listening mode |
| btn_beacon_i | input | 1 | Raw button selecting beacon mode |
| rx_data_i | input | DATA_W | Byte from the receiver |
| rx_valid_i | input | 1 | One-cycle strobe marking `rx_data_i` valid |
| tx_ready_i | input | 1 | Transmitter can take a byte this cycle |
| led_o | output | DATA_W | LED drives, bit i for LED i |
| tx_data_o | output | DATA_W | Byte offered to the transmitter |
| tx_valid_o | output | 1 | Offer present on `tx_data_o` |

## Verification
The bench builds the block with `SYNC_STAGES`=2 and `DEBOUNCE_CYCLES`=4. With such a short debounce window, a real press settles in about ten cycles. A two-cycle glitch can then be shown to fall short of the window. The other parameters keep their defaults (8-bit data, 0xFF pattern, active-high buttons and LEDs). That setting makes the all-ones beacon byte and the dark reset state of the LEDs directly observable. With a fast settle, the bench can press buttons many times between randomized stretches of receive strobes and ready toggling. This includes simultaneous presses and mode changes while an offer is still pending.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [1:0] {
      MODE_QUIET  = 2'd0,
      MODE_LISTEN = 2'd1,
      MODE_BEACON = 2'd2
   } smc_mode_e;

   localparam int unsigned NUM_BUTTONS = 3;
   localparam int unsigned BTN_QUIET   = 0;
   localparam int unsigned BTN_LISTEN  = 1;
   localparam int unsigned BTN_BEACON  = 2;

endpackage

// File: rtl/smc_btn_cond.sv
module smc_btn_cond #(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned DEBOUNCE_CYCLES = 500000,
   parameter bit          ACTIVE_LOW      = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_i,
   output logic press_o
);

   localparam int unsigned CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("smc_btn_cond: SYNC_STAGES must be at least 2");
      end
      if (DEBOUNCE_CYCLES < 1) begin : g_bad_db
         $error("smc_btn_cond: DEBOUNCE_CYCLES must be at least 1");
      end
   endgenerate

   logic level;

   generate
      if (ACTIVE_LOW) begin : g_pol_low
         assign level = ~btn_i;
      end else begin : g_pol_high
         assign level = btn_i;
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   clean;
   logic                   stable_q;
   logic [CNT_W-1:0]       cnt_q;
   logic                   press_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], level};
      end
   end

   assign clean = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stable_q <= 1'b0;
         cnt_q    <= '0;
         press_q  <= 1'b0;
      end else begin
         press_q <= 1'b0;
         if (clean == stable_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_LAST) begin
            cnt_q    <= '0;
            stable_q <= clean;
            press_q  <= clean;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign press_o = press_q;

   // R10: a press is a single-cycle event
   p_press_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      press_q |=> !press_q);

   // R10: a press only follows a completed debounce window
   p_press_needs_window_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != CNT_LAST) |=> !press_q);

endmodule

// File: rtl/smc_mode_fsm.sv
module smc_mode_fsm
   import smc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      press_quiet_i,
   input  logic      press_listen_i,
   input  logic      press_beacon_i,
   output smc_mode_e mode_o
);

   smc_mode_e mode_q;
   smc_mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      if (press_quiet_i) begin
         mode_d = MODE_QUIET;
      end else if (press_listen_i) begin
         mode_d = MODE_LISTEN;
      end else if (press_beacon_i) begin
         mode_d = MODE_BEACON;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_QUIET;
      end else begin
         mode_q <= mode_d;
      end
   end

   assign mode_o = mode_q;

   p_quiet_wins_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      press_quiet_i |=> (mode_q == MODE_QUIET));

   p_listen_over_beacon_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (press_listen_i && !press_quiet_i) |=> (mode_q == MODE_LISTEN));

   p_mode_holds_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !(press_quiet_i || press_listen_i || press_beacon_i) |=> $stable(mode_q));

   p_mode_legal_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != 2'd3);

endmodule

// File: rtl/smc_led_latch.sv
module smc_led_latch #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en_i,
   input  logic              strobe_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] led_o
);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("smc_led_latch: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] lit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lit_q <= '0;
      end else if (load_en_i && strobe_i) begin
         lit_q <= data_i;
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_drive_low
         assign led_o = ~lit_q;
      end else begin : g_drive_high
         assign led_o = lit_q;
      end
   endgenerate

   p_led_load_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (load_en_i && strobe_i) |=> (lit_q == $past(data_i)));

   p_led_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(load_en_i && strobe_i) |=> $stable(lit_q));

endmodule

// File: rtl/smc_tx_feeder.sv
module smc_tx_feeder #(
   parameter int unsigned       DATA_W  = 8,
   parameter logic [DATA_W-1:0] PATTERN = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);

   logic valid_q;
   logic valid_d;

   always_comb begin
      if (valid_q && ready_i) begin
         valid_d = run_i;
      end else begin
         valid_d = valid_q || run_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= valid_d;
      end
   end

   assign valid_o = valid_q;
   assign data_o  = valid_q ? PATTERN : '0;

   p_offer_kept_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready_i) |=> valid_q);

   p_no_start_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && !run_i) |=> !valid_q);

   p_back_to_back_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && ready_i && run_i) |=> valid_q);

   p_data_pattern_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (data_o == PATTERN));

endmodule

// File: rtl/serial_mode_ctrl.sv
module serial_mode_ctrl
   import smc_pkg::*;
#(
   parameter int unsigned       DATA_W          = 8,
   parameter logic [DATA_W-1:0] TX_PATTERN      = 8'hFF,
   parameter int unsigned       SYNC_STAGES     = 2,
   parameter int unsigned       DEBOUNCE_CYCLES = 500000,
   parameter bit                BTN_ACTIVE_LOW  = 1'b0,
   parameter bit                LED_ACTIVE_LOW  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_quiet_i,
   input  logic              btn_listen_i,
   input  logic              btn_beacon_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_valid_i,
   input  logic              tx_ready_i,
   output logic [DATA_W-1:0] led_o,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_valid_o
);

   logic [NUM_BUTTONS-1:0] btn_raw;
   logic [NUM_BUTTONS-1:0] press;
   smc_mode_e              mode;

   assign btn_raw[BTN_QUIET]  = btn_quiet_i;
   assign btn_raw[BTN_LISTEN] = btn_listen_i;
   assign btn_raw[BTN_BEACON] = btn_beacon_i;

   generate
      for (genvar b = 0; b < NUM_BUTTONS; b++) begin : g_btn
         smc_btn_cond #(
            .SYNC_STAGES     (SYNC_STAGES),
            .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
            .ACTIVE_LOW      (BTN_ACTIVE_LOW)
         ) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .btn_i   (btn_raw[b]),
            .press_o (press[b])
         );
      end
   endgenerate

   smc_mode_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .press_quiet_i  (press[BTN_QUIET]),
      .press_listen_i (press[BTN_LISTEN]),
      .press_beacon_i (press[BTN_BEACON]),
      .mode_o         (mode)
   );

   smc_led_latch #(
      .DATA_W     (DATA_W),
      .ACTIVE_LOW (LED_ACTIVE_LOW)
   ) u_led (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en_i (mode == MODE_LISTEN),
      .strobe_i  (rx_valid_i),
      .data_i    (rx_data_i),
      .led_o     (led_o)
   );

   smc_tx_feeder #(
      .DATA_W  (DATA_W),
      .PATTERN (TX_PATTERN)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (mode == MODE_BEACON),
      .ready_i (tx_ready_i),
      .valid_o (tx_valid_o),
      .data_o  (tx_data_o)
   );

   p_quiet_silent_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_QUIET) && !tx_valid_o) |=> !tx_valid_o);

   p_leds_frozen_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_LISTEN) |=> $stable(led_o));

   p_beacon_offers_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_BEACON) |=> tx_valid_o);

endmodule

// File: tb/tb_serial_mode_ctrl.sv
module tb_serial_mode_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int DB         = 4;
   localparam int SETTLE     = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          b_quiet = 1'b0, b_listen = 1'b0, b_beacon = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_valid = 1'b0;
   logic          tx_ready = 1'b0;
   logic [DW-1:0] led, tx_data;
   logic          tx_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_mode_ctrl #(
      .DATA_W(DW), .TX_PATTERN(8'hFF), .SYNC_STAGES(2),
      .DEBOUNCE_CYCLES(DB), .BTN_ACTIVE_LOW(1'b0), .LED_ACTIVE_LOW(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .btn_quiet_i(b_quiet), .btn_listen_i(b_listen), .btn_beacon_i(b_beacon),
      .rx_data_i(rx_data), .rx_valid_i(rx_valid), .tx_ready_i(tx_ready),
      .led_o(led), .tx_data_o(tx_data), .tx_valid_o(tx_valid)
   );

   // reference model: 0 quiet, 1 listen, 2 beacon
   int            m_mode = 0;
   logic [DW-1:0] m_led = '0;
   bit            m_valid = 1'b0;
   bit            cmp_en = 1'b0;
   string         cur_req = "R1";
   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (m_mode == 1 && rx_valid) m_led = rx_data;
         if (m_valid && tx_ready) m_valid = (m_mode == 2);
         else if (m_mode == 2)    m_valid = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         n_cmp++;
         if (led !== m_led) begin
            n_bad++;
            $display("FAIL %s led: actual %h expected %h", cur_req, led, m_led);
         end
         n_cmp++;
         if (tx_valid !== m_valid) begin
            n_bad++;
            $display("FAIL %s tx_valid: actual %b expected %b", cur_req, tx_valid, m_valid);
         end
         n_cmp++;
         if (tx_data !== (m_valid ? 8'hFF : 8'h00)) begin
            n_bad++;
            $display("FAIL %s tx_data: actual %h expected %h", cur_req, tx_data,
                     m_valid ? 8'hFF : 8'h00);
         end
      end
   end

   task automatic run(input int n, input int ready_mode, input bit send_rx);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = send_rx ? 1'($urandom_range(0, 1)) : 1'b0;
         rx_data  = 8'($urandom);
         tx_ready = (ready_mode == 2) ? 1'($urandom_range(0, 1)) : ready_mode[0];
      end
   endtask

   task automatic press(input bit q, input bit l, input bit t, input int nm);
      @(negedge clk);
      cmp_en = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
      b_quiet = q; b_listen = l; b_beacon = t;
      repeat (SETTLE) @(negedge clk);
      b_quiet = 1'b0; b_listen = 1'b0; b_beacon = 1'b0;
      repeat (SETTLE) @(negedge clk);
      m_mode = nm;
      if (nm == 2) m_valid = 1'b1;
      cmp_en = 1'b1;
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cur_req = "R1"; cmp_en = 1'b1;
      run(5, 0, 1'b0);
      // R2/R4: quiet mode ignores rx and ready
      cur_req = "R2_R4";
      run(60, 2, 1'b1);
      // R10: short glitch on beacon button must not start offers
      cur_req = "R10";
      @(negedge clk); b_beacon = 1'b1;
      repeat (2) @(negedge clk); b_beacon = 1'b0;
      run(30, 2, 1'b1);
      // R3: listening mode shows received bytes
      cur_req = "R3";
      press(1'b0, 1'b1, 1'b0, 1);
      run(200, 2, 1'b1);
      // R5/R6/R7: beacon mode, LEDs hold, back-to-back offers
      cur_req = "R5_R6";
      press(1'b0, 1'b0, 1'b1, 2);
      run(100, 2, 1'b1);
      cur_req = "R7";
      run(50, 1, 1'b1);
      // R8: leave beacon with the offer pending
      cur_req = "R8";
      press(1'b1, 1'b0, 1'b0, 0);
      run(10, 0, 1'b1);
      run(40, 2, 1'b1);
      // R9: simultaneous presses
      cur_req = "R9";
      press(1'b0, 1'b1, 1'b1, 1);
      run(60, 2, 1'b1);
      press(1'b1, 1'b1, 1'b1, 0);
      run(60, 2, 1'b1);
      press(1'b0, 1'b0, 1'b1, 2);
      run(40, 2, 1'b1);
      press(1'b1, 1'b0, 1'b1, 0);
      run(40, 2, 1'b1);
      finish_up();
   end

endmodule